// File: doc/BRIEF.md
# Descriptor-Fed CRC DMA Front End

This block feeds a CRC engine from memory. Software places a small descriptor in memory at a 512-byte-aligned address and writes that address into the block. Software then sets the DMA going with a one-shot strobe. The block reads the descriptor, which holds the start address of the data window and a control word. It then issues byte, halfword or word reads for the programmed number of transfers. Each datum that returns is handed to the CRC engine as a single-cycle beat, zero-extended to 32 bits and tagged with its width.

The memory side is a request/response read port with one read outstanding at a time. A request is held until the memory accepts it. The data comes back later as a one-cycle response. When the last transfer has returned, the block drops its busy bit and raises a completion flag. It drives the interrupt output only when the software mask allows it and the descriptor's interrupt flag allows it. A second one-shot strobe stops a running transfer at once.

Top module: `crc_desc_dma`

## Requirements
- R1: Register map, addressed by byte offset on `reg_addr` with bits [1:0] equal to zero: 0x00 descriptor base (read/write), 0x04 start strobe, 0x08 stop strobe, 0x0C busy bit (read-only), 0x10 interrupt-mask set strobe, 0x14 interrupt-mask clear strobe, 0x18 mask bit (read-only), 0x1C completion flag (read-only). Strobes act on a write with bit 0 set and read as zero. The base register keeps only bits [31:9], so its bits [8:0] always read as zero.
- R2: After a start strobe, the block first reads the word at the base address, which is the data start address. Next it reads the word at base+4, which is the control word. Only after both does it issue data reads. Every descriptor read has size code 2, and a request holds its address and size until it is accepted.
- R3: Control word bits [15:0] give the number of data reads, from 0 to 65535, and exactly that many beats reach the CRC port.
- R4: Control word bits [25:24] select the transfer width: 0 for byte, 1 for halfword, 2 for word. Each data read carries that code on `mem_req_size`, and the address steps by 1, 2 or 4 from the start address. The size code 3 is never issued.
- R5: Each data response leads to one `crc_valid` beat on the following cycle. The beat carries the low 8, 16 or 32 bits of `mem_rsp_data`, zero-extended, with `crc_size` equal to the width code.
- R6: The busy bit reads 1 from the cycle after an accepted start strobe until the transfer completes or is stopped. No memory request is issued while it is 0.
- R7: A stop strobe during a transfer returns the block to idle on the next cycle. After that, no further requests or beats are produced and the completion flag is not set, even if a response is still in flight.
- R8: The completion flag is set when the final response is taken and cleared by the next accepted start strobe.
- R9: `irq` equals completion flag AND mask bit AND (control word bit 27 == 0). Bit 27 is active low, so 1 suppresses the interrupt. The mask bit is set by the strobe at 0x10 and cleared by the strobe at 0x14.
- R10: A transfer count of zero completes right after the control word returns, with no data read and no beat, and sets the completion flag.
- R11: A start strobe while busy is ignored: the descriptor is not fetched again and the transfer in progress runs to its programmed count.
- R12: After reset, all readable registers read zero, and `irq`, `mem_req_valid` and `crc_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write enable |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req_valid | output | 1 | Read request pending |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | 32 | Read byte address |
| mem_req_size | output | 2 | Read size code: 0 byte, 1 halfword, 2 word |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 32 | Returned data, right-justified |
| crc_valid | output | 1 | Beat to the CRC engine |
| crc_data | output | 32 | Beat data, zero-extended |
| crc_size | output | 2 | Width code of the beat |
| irq | output | 1 | Completion interrupt |

## Verification
The properties assume a well-behaved memory. It returns exactly one response per accepted request, never sends a response while no read is outstanding, and keeps `mem_rsp_data` right-justified for narrow reads. They also assume software issues at most one register write per cycle. The bench's memory model answers each accepted request after a programmable latency. It only varies `mem_req_ready` between cycles, so an acceptance is always seen on a held request. The single stray response that can follow a stop strobe lands while the block is idle, which the design must tolerate and the bench checks.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

    localparam int WORD_W     = 32;
    localparam int CNT_W      = 16;
    localparam int DESC_ALIGN = 9;
    localparam int REG_AW     = 5;

    typedef enum logic [1:0] {
        XW_BYTE = 2'd0,
        XW_HALF = 2'd1,
        XW_WORD = 2'd2
    } xw_e;

    typedef enum logic [2:0] {
        REG_BASE   = 3'd0,
        REG_GO     = 3'd1,
        REG_HALT   = 3'd2,
        REG_BUSY   = 3'd3,
        REG_ARM    = 3'd4,
        REG_DISARM = 3'd5,
        REG_MASK   = 3'd6,
        REG_FLAG   = 3'd7
    } reg_idx_e;

    typedef enum logic [2:0] {
        SQ_IDLE     = 3'd0,
        SQ_ADDR_REQ = 3'd1,
        SQ_ADDR_RSP = 3'd2,
        SQ_CTRL_REQ = 3'd3,
        SQ_CTRL_RSP = 3'd4,
        SQ_DATA_REQ = 3'd5,
        SQ_DATA_RSP = 3'd6
    } seq_st_e;

    typedef struct packed {
        logic             quiet;
        xw_e              width;
        logic [CNT_W-1:0] count;
    } xfer_ctrl_t;

    // Control word: [15:0] count, [25:24] width, [27] active-low notify.
    function automatic xfer_ctrl_t decode_ctrl(input logic [WORD_W-1:0] w);
        xfer_ctrl_t c;
        c.count = w[CNT_W-1:0];
        c.quiet = w[27];
        case (w[25:24])
            2'd0:    c.width = XW_BYTE;
            2'd1:    c.width = XW_HALF;
            default: c.width = XW_WORD;
        endcase
        return c;
    endfunction

    function automatic logic [2:0] step_of(input xw_e w);
        case (w)
            XW_BYTE: return 3'd1;
            XW_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] lane_fit(input logic [WORD_W-1:0] d, input xw_e w);
        case (w)
            XW_BYTE: return {{(WORD_W-8){1'b0}}, d[7:0]};
            XW_HALF: return {{(WORD_W-16){1'b0}}, d[15:0]};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/cdma_regs.sv
module cdma_regs
    import cdma_pkg::*;
#(
    parameter int ALIGN = DESC_ALIGN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              flag,
    output logic              go,
    output logic              halt,
    output logic [WORD_W-1:0] base_o,
    output logic              mask_o
);

    logic     hit;
    reg_idx_e idx;
    logic     strobe_bit;
    logic     unused_wbits;

    assign hit          = (reg_addr[1:0] == 2'b00);
    assign idx          = reg_idx_e'(reg_addr[REG_AW-1:2]);
    assign strobe_bit   = reg_wdata[0];
    assign unused_wbits = ^reg_wdata[ALIGN-1:1];

    assign go   = reg_wen && hit && (idx == REG_GO)   && strobe_bit;
    assign halt = reg_wen && hit && (idx == REG_HALT) && strobe_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_o <= '0;
            mask_o <= 1'b0;
        end else if (reg_wen && hit) begin
            case (idx)
                REG_BASE:   base_o <= {reg_wdata[WORD_W-1:ALIGN], {ALIGN{1'b0}}};
                REG_ARM:    if (strobe_bit) mask_o <= 1'b1;
                REG_DISARM: if (strobe_bit) mask_o <= 1'b0;
                default:    ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            case (idx)
                REG_BASE: reg_rdata = base_o;
                REG_BUSY: reg_rdata = {{(WORD_W-1){1'b0}}, busy};
                REG_MASK: reg_rdata = {{(WORD_W-1){1'b0}}, mask_o};
                REG_FLAG: reg_rdata = {{(WORD_W-1){1'b0}}, flag};
                default:  reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/cdma_seq.sv
module cdma_seq
    import cdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              halt,
    input  logic [WORD_W-1:0] base_i,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [WORD_W-1:0] mem_req_addr,
    output logic [1:0]        mem_req_size,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              crc_valid,
    output logic [WORD_W-1:0] crc_data,
    output logic [1:0]        crc_size,
    output logic              active,
    output logic              done_evt,
    output logic              done_notify
);

    seq_st_e          state;
    logic [WORD_W-1:0] desc_q;
    logic [WORD_W-1:0] cur_addr;
    logic [CNT_W-1:0]  remain;
    xw_e               width_q;
    xw_e               beat_w_q;
    logic              quiet_q;
    xfer_ctrl_t        cw;

    assign cw     = decode_ctrl(mem_rsp_data);
    assign active = (state != SQ_IDLE);

    assign mem_req_valid = (state == SQ_ADDR_REQ) || (state == SQ_CTRL_REQ) ||
                           (state == SQ_DATA_REQ);

    always_comb begin
        case (state)
            SQ_ADDR_REQ: mem_req_addr = desc_q;
            SQ_CTRL_REQ: mem_req_addr = desc_q + WORD_W'(4);
            SQ_DATA_REQ: mem_req_addr = cur_addr;
            default:     mem_req_addr = '0;
        endcase
    end

    assign mem_req_size = (state == SQ_DATA_REQ) ? width_q : XW_WORD;
    assign crc_size     = beat_w_q;

    assign done_evt = !halt && mem_rsp_valid &&
                      (((state == SQ_CTRL_RSP) && (cw.count == '0)) ||
                       ((state == SQ_DATA_RSP) && (remain == CNT_W'(1))));
    assign done_notify = (state == SQ_CTRL_RSP) ? !cw.quiet : !quiet_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            desc_q    <= '0;
            cur_addr  <= '0;
            remain    <= '0;
            width_q   <= XW_BYTE;
            beat_w_q  <= XW_BYTE;
            quiet_q   <= 1'b0;
            crc_valid <= 1'b0;
            crc_data  <= '0;
        end else begin
            crc_valid <= 1'b0;
            if (halt && state != SQ_IDLE) begin
                state <= SQ_IDLE;
            end else begin
                case (state)
                    SQ_IDLE: begin
                        if (go) begin
                            desc_q <= base_i;
                            state  <= SQ_ADDR_REQ;
                        end
                    end
                    SQ_ADDR_REQ: if (mem_req_ready) state <= SQ_ADDR_RSP;
                    SQ_ADDR_RSP: begin
                        if (mem_rsp_valid) begin
                            cur_addr <= mem_rsp_data;
                            state    <= SQ_CTRL_REQ;
                        end
                    end
                    SQ_CTRL_REQ: if (mem_req_ready) state <= SQ_CTRL_RSP;
                    SQ_CTRL_RSP: begin
                        if (mem_rsp_valid) begin
                            width_q <= cw.width;
                            remain  <= cw.count;
                            quiet_q <= cw.quiet;
                            state   <= (cw.count == '0) ? SQ_IDLE : SQ_DATA_REQ;
                        end
                    end
                    SQ_DATA_REQ: if (mem_req_ready) state <= SQ_DATA_RSP;
                    SQ_DATA_RSP: begin
                        if (mem_rsp_valid) begin
                            crc_valid <= 1'b1;
                            crc_data  <= lane_fit(mem_rsp_data, width_q);
                            beat_w_q  <= width_q;
                            cur_addr  <= cur_addr + WORD_W'(step_of(width_q));
                            remain    <= remain - CNT_W'(1);
                            state     <= (remain == CNT_W'(1)) ? SQ_IDLE : SQ_DATA_REQ;
                        end
                    end
                    default: state <= SQ_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/cdma_irq.sv
module cdma_irq (
    input  logic clk,
    input  logic rst,
    input  logic go_acc,
    input  logic done_evt,
    input  logic done_notify,
    input  logic mask,
    output logic flag,
    output logic irq
);

    logic allow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag    <= 1'b0;
            allow_q <= 1'b0;
        end else if (go_acc) begin
            flag <= 1'b0;
        end else if (done_evt) begin
            flag    <= 1'b1;
            allow_q <= done_notify;
        end
    end

    assign irq = flag && mask && allow_q;

endmodule

// File: rtl/crc_desc_dma.sv
module crc_desc_dma
    import cdma_pkg::*;
#(
    parameter int ALIGN = DESC_ALIGN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [WORD_W-1:0] mem_req_addr,
    output logic [1:0]        mem_req_size,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              crc_valid,
    output logic [WORD_W-1:0] crc_data,
    output logic [1:0]        crc_size,
    output logic              irq
);

    logic              go;
    logic              halt;
    logic [WORD_W-1:0] base_q;
    logic              irq_mask;
    logic              irq_flag;
    logic              dma_active;
    logic              done_evt;
    logic              done_notify;

    cdma_regs #(.ALIGN(ALIGN)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (dma_active),
        .flag      (irq_flag),
        .go        (go),
        .halt      (halt),
        .base_o    (base_q),
        .mask_o    (irq_mask)
    );

    cdma_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .go            (go),
        .halt          (halt),
        .base_i        (base_q),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_req_size  (mem_req_size),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .crc_valid     (crc_valid),
        .crc_data      (crc_data),
        .crc_size      (crc_size),
        .active        (dma_active),
        .done_evt      (done_evt),
        .done_notify   (done_notify)
    );

    cdma_irq u_irq (
        .clk         (clk),
        .rst         (rst),
        .go_acc      (go && !dma_active),
        .done_evt    (done_evt),
        .done_notify (done_notify),
        .mask        (irq_mask),
        .flag        (irq_flag),
        .irq         (irq)
    );

endmodule

// File: rtl/cdma_checker.sv
module cdma_checker (
    input logic        clk,
    input logic        rst,
    input logic        reg_wen,
    input logic [4:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic [1:0]  mem_req_size,
    input logic        mem_rsp_valid,
    input logic        crc_valid,
    input logic [31:0] crc_data,
    input logic [1:0]  crc_size,
    input logic        irq,
    input logic        busy,
    input logic        mask
);

    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size));

    p_size_legal_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_req_size != 2'd3);

    p_beat_after_rsp_r5: assert property (@(posedge clk) disable iff (rst)
        crc_valid |-> $past(mem_rsp_valid));

    p_byte_fit_r5: assert property (@(posedge clk) disable iff (rst)
        crc_valid && crc_size == 2'd0 |-> crc_data[31:8] == 24'd0);

    p_half_fit_r5: assert property (@(posedge clk) disable iff (rst)
        crc_valid && crc_size == 2'd1 |-> crc_data[31:16] == 16'd0);

    p_req_busy_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> busy);

    p_halt_idle_r7: assert property (@(posedge clk) disable iff (rst)
        reg_wen && reg_addr == 5'h08 && reg_wdata[0] |=> !busy && !mem_req_valid);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> mask);

endmodule

bind crc_desc_dma cdma_checker u_cdma_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_wen       (reg_wen),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_size  (mem_req_size),
    .mem_rsp_valid (mem_rsp_valid),
    .crc_valid     (crc_valid),
    .crc_data      (crc_data),
    .crc_size      (crc_size),
    .irq           (irq),
    .busy          (dma_active),
    .mask          (irq_mask)
);

// File: tb/crc_desc_dma_bench.sv
module crc_desc_dma_bench;

    localparam logic [4:0] A_BASE   = 5'h00;
    localparam logic [4:0] A_GO     = 5'h04;
    localparam logic [4:0] A_HALT   = 5'h08;
    localparam logic [4:0] A_BUSY   = 5'h0C;
    localparam logic [4:0] A_ARM    = 5'h10;
    localparam logic [4:0] A_DISARM = 5'h14;
    localparam logic [4:0] A_MASK   = 5'h18;
    localparam logic [4:0] A_FLAG   = 5'h1C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wen = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic [1:0]  mem_req_size;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        crc_valid;
    logic [31:0] crc_data;
    logic [1:0]  crc_size;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    // memory model and monitor state
    int          lat = 1;
    bit          stall = 0;
    logic [31:0] desc_base = '0;
    logic [31:0] desc_start = '0;
    logic [31:0] desc_ctrl = '0;
    int          pend_cnt = 0;
    logic [31:0] pend_addr = '0;
    int          cyc = 0;
    int          req_cnt = 0;
    int          beat_cnt = 0;
    int          beat_err = 0;
    logic [31:0] req_addr [256];
    logic [1:0]  req_size [256];
    logic [31:0] beat_data [256];

    always #4 clk = ~clk;

    crc_desc_dma u_crc_desc_dma (
        .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .crc_valid(crc_valid), .crc_data(crc_data), .crc_size(crc_size),
        .irq(irq)
    );

    function automatic logic [31:0] dfun(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [31:0] fit(input logic [31:0] d, input logic [1:0] w);
        if (w == 2'd0) return {24'd0, d[7:0]};
        if (w == 2'd1) return {16'd0, d[15:0]};
        return d;
    endfunction

    function automatic logic [31:0] mk_ctrl(input bit quiet, input logic [1:0] w,
                                             input logic [15:0] cnt);
        return {4'd0, quiet, 1'b0, w, 8'd0, cnt};
    endfunction

    function automatic logic [31:0] lookup(input logic [31:0] a);
        if (a == desc_base) return desc_start;
        if (a == desc_base + 32'd4) return desc_ctrl;
        return dfun(a);
    endfunction

    // memory model and beat monitor, all on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (crc_valid) begin
                if (beat_cnt < 256) beat_data[beat_cnt] = crc_data;
                beat_cnt++;
                if (!mem_rsp_valid || crc_data != fit(mem_rsp_data, crc_size)) beat_err++;
            end
            mem_req_ready = stall ? ((cyc % 3) != 0) : 1'b1;
            mem_rsp_valid = 1'b0;
            if (pend_cnt > 0) begin
                pend_cnt--;
                if (pend_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = lookup(pend_addr);
                end
            end
            if (mem_req_valid && mem_req_ready) begin
                if (req_cnt < 256) begin
                    req_addr[req_cnt] = mem_req_addr;
                    req_size[req_cnt] = mem_req_size;
                end
                req_cnt++;
                pend_addr = mem_req_addr;
                pend_cnt  = lat;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            reg_read(A_BUSY, v);
            if (v == 32'd0) break;
        end
    endtask

    task automatic launch(input logic [31:0] base, input logic [31:0] start,
                          input logic [31:0] ctrl, input int l, input bit s);
        logic [31:0] v;
        desc_base = base; desc_start = start; desc_ctrl = ctrl;
        lat = l; stall = s;
        req_cnt = 0; beat_cnt = 0; beat_err = 0;
        reg_write(A_BASE, base | 32'h1FF);
        reg_write(A_GO, 32'd1);
        reg_read(A_BUSY, v);
        chk(v == 32'd1, "R6 busy after start", v, 32'd1);
    endtask

    task automatic verify_stream(input logic [31:0] start, input logic [1:0] w, input int n);
        int bad_addr = 0;
        int bad_data = 0;
        int step = (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
        chk(req_cnt == n + 2, "R3 request count", req_cnt, n + 2);
        chk(req_addr[0] == desc_base && req_size[0] == 2'd2, "R2 first read at base",
            req_addr[0], desc_base);
        chk(req_addr[1] == desc_base + 32'd4 && req_size[1] == 2'd2,
            "R2 second read at base+4", req_addr[1], desc_base + 32'd4);
        for (int k = 0; k < n && k + 2 < 256; k++) begin
            if (req_addr[k+2] != start + 32'(k * step) || req_size[k+2] != w) bad_addr++;
            if (k < 256 && beat_data[k] != fit(dfun(start + 32'(k * step)), w)) bad_data++;
        end
        chk(bad_addr == 0, "R4 data address step and size", bad_addr, 0);
        chk(beat_cnt == n, "R3 beat count", beat_cnt, n);
        chk(bad_data == 0, "R5 beat data", bad_data, 0);
        chk(beat_err == 0, "R5 beat follows response", beat_err, 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_read(A_BASE, v); chk(v == 0, "R12 base after reset", v, 0);
        reg_read(A_BUSY, v); chk(v == 0, "R12 busy after reset", v, 0);
        reg_read(A_MASK, v); chk(v == 0, "R12 mask after reset", v, 0);
        reg_read(A_FLAG, v); chk(v == 0, "R12 flag after reset", v, 0);
        chk(!irq && !mem_req_valid && !crc_valid, "R12 outputs idle",
            {irq, mem_req_valid, crc_valid}, 0);
    endtask

    task automatic t_base();
        logic [31:0] v;
        reg_write(A_BASE, 32'hFFFF_FFFF);
        reg_read(A_BASE, v);
        chk(v == 32'hFFFF_FE00, "R1 base low bits dropped", v, 32'hFFFF_FE00);
        reg_read(A_GO, v);
        chk(v == 0, "R1 strobe reads zero", v, 0);
    endtask

    task automatic t_word();
        logic [31:0] v;
        reg_write(A_ARM, 32'd1);
        reg_read(A_MASK, v); chk(v == 1, "R9 mask armed", v, 1);
        launch(32'h0000_2200, 32'h0000_1000, mk_ctrl(1'b0, 2'd2, 16'd5), 1, 1'b0);
        wait_idle();
        verify_stream(32'h0000_1000, 2'd2, 5);
        reg_read(A_FLAG, v); chk(v == 1, "R8 flag at completion", v, 1);
        chk(irq == 1'b1, "R9 irq raised", irq, 1);
    endtask

    task automatic t_byte_quiet();
        logic [31:0] v;
        launch(32'h0000_4400, 32'h0000_3003, mk_ctrl(1'b1, 2'd0, 16'd6), 3, 1'b1);
        wait_idle();
        verify_stream(32'h0000_3003, 2'd0, 6);
        reg_read(A_FLAG, v); chk(v == 1, "R8 flag with quiet descriptor", v, 1);
        chk(irq == 1'b0, "R9 bit27 suppresses irq", irq, 0);
    endtask

    task automatic t_half_masked();
        logic [31:0] v;
        reg_write(A_DISARM, 32'd1);
        reg_read(A_MASK, v); chk(v == 0, "R9 mask cleared", v, 0);
        desc_base = 32'h0000_6000; desc_start = 32'h0000_0102;
        desc_ctrl = mk_ctrl(1'b0, 2'd1, 16'd4); lat = 2; stall = 1'b0;
        req_cnt = 0; beat_cnt = 0; beat_err = 0;
        reg_write(A_BASE, desc_base);
        reg_write(A_GO, 32'd1);
        reg_read(A_FLAG, v); chk(v == 0, "R8 flag cleared by start", v, 0);
        wait_idle();
        verify_stream(32'h0000_0102, 2'd1, 4);
        chk(irq == 1'b0, "R9 mask blocks irq", irq, 0);
        reg_write(A_ARM, 32'd1);
        #1 chk(irq == 1'b1, "R9 irq after arming", irq, 1);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        launch(32'h0000_8200, 32'h0000_5000, mk_ctrl(1'b0, 2'd2, 16'd0), 1, 1'b0);
        wait_idle();
        chk(req_cnt == 2, "R10 only descriptor reads", req_cnt, 2);
        chk(beat_cnt == 0, "R10 no beats", beat_cnt, 0);
        reg_read(A_FLAG, v); chk(v == 1, "R10 flag set", v, 1);
        chk(irq == 1'b1, "R10 irq on empty transfer", irq, 1);
    endtask

    task automatic t_halt();
        logic [31:0] v;
        int rq;
        int bt;
        launch(32'h0000_A000, 32'h0001_0000, mk_ctrl(1'b0, 2'd2, 16'd200), 2, 1'b0);
        repeat (30) @(negedge clk);
        reg_write(A_HALT, 32'd1);
        reg_read(A_BUSY, v); chk(v == 0, "R7 idle after stop", v, 0);
        rq = req_cnt; bt = beat_cnt;
        repeat (20) @(negedge clk);
        chk(req_cnt == rq, "R7 no requests after stop", req_cnt, rq);
        chk(beat_cnt == bt && bt < 200, "R7 no beats after stop", beat_cnt, bt);
        reg_read(A_FLAG, v); chk(v == 0, "R7 flag stays clear", v, 0);
        chk(irq == 1'b0, "R7 no irq", irq, 0);
    endtask

    task automatic t_rego();
        logic [31:0] v;
        int desc_hits = 0;
        launch(32'h0000_C000, 32'h0002_0000, mk_ctrl(1'b0, 2'd2, 16'd10), 2, 1'b0);
        repeat (8) @(negedge clk);
        reg_write(A_GO, 32'd1);
        wait_idle();
        for (int k = 0; k < req_cnt && k < 256; k++)
            if (req_addr[k] == desc_base) desc_hits++;
        chk(desc_hits == 1, "R11 descriptor fetched once", desc_hits, 1);
        verify_stream(32'h0002_0000, 2'd2, 10);
        reg_read(A_FLAG, v); chk(v == 1, "R11 transfer completed", v, 1);
    endtask

    task automatic summary();
        ended = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!ended) begin
            n_chk++; n_fail++;
            $display("FAIL R6 watchdog actual=running expected=idle");
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_base();
        t_word();
        t_byte_quiet();
        t_half_masked();
        t_zero();
        t_halt();
        t_rego();
        repeat (5) @(negedge clk);
        summary();
    end

endmodule